// File: doc/BRIEF.md
# Four-Channel DAC Serial Load Controller

This block is the digital front end of a four-channel current-output converter. A host writes 24-bit words over a three-wire serial port. The port has an active-low frame strobe, a serial clock, and a data line. Each word carries a channel address and a 16-bit straight-binary code. When the frame closes, the block checks the bit count and the address. If both are valid, it stores the code in that channel's holding register.

An active-low update input decides when codes reach the output-code registers that feed the converter cores:

- **Update low during a write:** the addressed channel follows at the end of the frame.
- **Update high during writes:** outputs keep their values. The first code written to each channel in that window is kept aside. All such channels then change together when the update input falls.

A mode input adds an 8-bit check byte to each frame. Its content is not interpreted here; only the frame length changes. After reset, a busy flag blocks all writes for a fixed time, which leaves room for internal calibration. All four inputs are asynchronous to the system clock and are resynchronised inside the block.

Top module: `qdac_loader`

## Requirements
- R1: While reset is asserted, every holding register and every output code is zero and busy is high.
- R2: After reset is released, busy stays high for CLK_MHZ*BUSY_US clock cycles and then stays low. A frame that ends while busy is high changes no register.
- R3: In plain mode (chk_mode=0), a frame is 24 bits, sent MSB first and sampled on the falling serial clock. Word bits 20:16 are the address and bits 15:0 are the code. Address values 0 to 3 select channels 0 to 3, and the code is stored unchanged as straight binary.
- R4: With chk_mode=1, a frame is 32 bits. The first 24 bits form the word with the R3 layout, and the final 8 check bits do not affect what is stored.
- R5: A frame whose bit count at the rising frame strobe is not exactly 24 (plain mode) or 32 (check mode) changes no register.
- R6: A frame whose address is 4 or higher changes no register.
- R7: With upd_n low, a valid write updates the addressed channel's output code at frame end and leaves the other channels unchanged.
- R8: While upd_n stays high, no output code changes.
- R9: When upd_n falls, every channel written since upd_n rose takes the code of its first write in that window. Channels not written in that window keep their output code.
- R10: A second or later write to the same channel while upd_n is high updates its holding register but is not the value transferred at the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_mode | input | 1 | 1 selects 32-bit frames with a trailing check byte |
| frm_n | input | 1 | Serial frame strobe, active low |
| sck | input | 1 | Serial clock; data sampled on its falling edge |
| sdi | input | 1 | Serial data, MSB first |
| upd_n | input | 1 | Update control: low = per-write update, high = hold for group update |
| busy | output | 1 | High during the post-reset calibration window |
| hold_codes | output | NCH*DW | Holding registers, channel g at bits g*DW +: DW |
| dac_codes | output | NCH*DW | Output codes to the converter cores, same packing |

## Verification
The bench builds the block with CLK_MHZ=1 and BUSY_US=400, which makes the busy window 400 cycles. That is long enough for a whole serial frame to end inside it, so the rejection of writes during busy is observed directly. It is also short enough that the exact cycle where busy falls is checked within a few hundred cycles. NCH and DW keep their defaults, so address 4 is the first invalid address and all four channels can be seen at the ports.

// File: rtl/qdac_loader.sv
module qdac_loader #(
  parameter int NCH     = 4,
  parameter int DW      = 16,
  parameter int CLK_MHZ = 200,
  parameter int BUSY_US = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_mode,
  input  logic              frm_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              upd_n,
  output logic              busy,
  output logic [NCH*DW-1:0] hold_codes,
  output logic [NCH*DW-1:0] dac_codes
);

  localparam int BUSY_CYC = CLK_MHZ * BUSY_US;
  localparam int BCW      = $clog2(BUSY_CYC + 1);
  localparam int AW       = 5;
  localparam int SRW      = 29;
  localparam logic [AW-1:0] NCH_A = AW'(NCH);

  logic [2:0] frm_q, sck_q, upd_q;
  logic [1:0] sdi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q <= '1;
      sck_q <= '0;
      upd_q <= '1;
      sdi_q <= '0;
    end else begin
      frm_q <= {frm_q[1:0], frm_n};
      sck_q <= {sck_q[1:0], sck};
      upd_q <= {upd_q[1:0], upd_n};
      sdi_q <= {sdi_q[0], sdi};
    end
  end

  wire frm_lo   = ~frm_q[1];
  wire frm_fall = frm_q[2] & ~frm_q[1];
  wire frm_rise = ~frm_q[2] & frm_q[1];
  wire sck_fall = sck_q[2] & ~sck_q[1];
  wire upd_lvl  = upd_q[1];
  wire upd_rise = ~upd_q[2] & upd_q[1];
  wire upd_fall = upd_q[2] & ~upd_q[1];

  logic [SRW-1:0] shr;
  logic [5:0]     nbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shr   <= '0;
      nbits <= '0;
    end else if (frm_fall) begin
      nbits <= '0;
    end else if (frm_lo && sck_fall) begin
      shr <= {shr[SRW-2:0], sdi_q[1]};
      if (nbits != 6'd63) nbits <= nbits + 6'd1;
    end
  end

  logic [BCW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      if (bcnt == BCW'(BUSY_CYC - 1)) busy <= 1'b0;
      else bcnt <= bcnt + 1'b1;
    end
  end

  wire [5:0]    need_len = chk_mode ? 6'd32 : 6'd24;
  wire [AW-1:0] wr_addr  = chk_mode ? shr[28:24] : shr[20:16];
  wire [DW-1:0] wr_data  = chk_mode ? shr[23:8]  : shr[15:0];
  wire          frame_ok = frm_rise && !busy && (nbits == need_len) && (wr_addr < NCH_A);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] hold, pend, code;
    logic          armed;
    wire           hit = frame_ok && (wr_addr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold  <= '0;
        pend  <= '0;
        code  <= '0;
        armed <= 1'b0;
      end else begin
        if (hit) hold <= wr_data;
        if (hit && upd_lvl && (!armed || upd_rise)) begin
          armed <= 1'b1;
          pend  <= wr_data;
        end else if (upd_rise) begin
          armed <= 1'b0;
        end
        if (hit && !upd_lvl)      code <= wr_data;
        else if (upd_fall && armed) code <= pend;
      end
    end

    assign hold_codes[g*DW +: DW] = hold;
    assign dac_codes[g*DW +: DW]  = code;
  end

endmodule

// File: rtl/qdac_loader_chk.sv
module qdac_loader_chk #(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [NCH*DW-1:0] hold_codes,
  input logic [NCH*DW-1:0] dac_codes,
  input logic [2:0]        upd_q
);

  logic [NCH*DW-1:0] prev_dac;
  logic [NCH-1:0]    chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_dac <= '0;
    else        prev_dac <= dac_codes;
  end

  always_comb begin
    for (int i = 0; i < NCH; i++)
      chg[i] = dac_codes[i*DW +: DW] != prev_dac[i*DW +: DW];
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (dac_codes == '0 && hold_codes == '0 && busy));

  a_r2_busy_blocks_writes: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(hold_codes));

  a_r2_busy_never_returns: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);

  a_r8_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q[1] && upd_q[2]) |=> $stable(dac_codes));

  a_r7_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_q[2] && !upd_q[1]) |=> ($countones(chg) <= 1));

endmodule

bind qdac_loader qdac_loader_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .hold_codes(hold_codes), .dac_codes(dac_codes), .upd_q(upd_q)
);

// File: tb/qdac_loader_bench.sv
module qdac_loader_bench;
  localparam int NCH = 4, DW = 16, CLK_MHZ = 1, BUSY_US = 400;
  localparam int BUSY_CYC = CLK_MHZ * BUSY_US;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chk_mode = 1'b0, frm_n = 1'b1, sck = 1'b0, sdi = 1'b0, upd_n = 1'b0;
  logic busy;
  logic [NCH*DW-1:0] hold_codes, dac_codes;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;
  logic [DW-1:0] e_hold [NCH];
  logic [DW-1:0] e_dac  [NCH];

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  qdac_loader #(.NCH(NCH), .DW(DW), .CLK_MHZ(CLK_MHZ), .BUSY_US(BUSY_US)) u_qdac_loader (
    .clk(clk), .rst_n(rst_n), .chk_mode(chk_mode), .frm_n(frm_n), .sck(sck), .sdi(sdi),
    .upd_n(upd_n), .busy(busy), .hold_codes(hold_codes), .dac_codes(dac_codes)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NCH; i++) begin
      check(req, $sformatf("hold[%0d]", i), 32'(hold_codes[i*DW +: DW]), 32'(e_hold[i]));
      check(req, $sformatf("dac[%0d]", i),  32'(dac_codes[i*DW +: DW]),  32'(e_dac[i]));
    end
  endtask

  task automatic send(input logic [31:0] w, input int len);
    frm_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) begin
      sdi = w[i];
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
      repeat (4) @(negedge clk);
    end
    frm_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [31:0] word(input logic [4:0] a, input logic [15:0] d);
    return {8'h00, 3'b000, a, d};
  endfunction

  task automatic set_upd(input logic v);
    upd_n = v;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset_busy;
    for (int i = 0; i < NCH; i++) begin e_hold[i] = '0; e_dac[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", 32'(busy), 32'd1);
    check_all("R1");
    rst_n = 1'b1;
    send(word(5'd1, 16'hAAAA), 24);
    check_all("R2");
    wait (cyc == BUSY_CYC - 2); @(negedge clk);
    check("R2", "busy before end", 32'(busy), 32'd1);
    wait (cyc == BUSY_CYC + 2); @(negedge clk);
    check("R2", "busy after end", 32'(busy), 32'd0);
  endtask

  task automatic t_individual;
    set_upd(1'b0);
    send(word(5'd2, 16'hBEEF), 24); e_hold[2] = 16'hBEEF; e_dac[2] = 16'hBEEF;
    check_all("R7");
    send(word(5'd0, 16'h0001), 24); e_hold[0] = 16'h0001; e_dac[0] = 16'h0001;
    send(word(5'd3, 16'hFFFF), 24); e_hold[3] = 16'hFFFF; e_dac[3] = 16'hFFFF;
    check_all("R3");
  endtask

  task automatic t_bad_addr;
    send(word(5'd4, 16'h1234), 24);
    send(word(5'd31, 16'h5678), 24);
    check_all("R6");
  endtask

  task automatic t_bad_len;
    send(word(5'd1, 16'h7777) >> 1, 23);
    send({word(5'd1, 16'h7777), 1'b0}, 25);
    check_all("R5");
  endtask

  task automatic t_check_mode;
    chk_mode = 1'b1;
    send({word(5'd1, 16'h5A5A), 8'hC3} , 32); e_hold[1] = 16'h5A5A; e_dac[1] = 16'h5A5A;
    check_all("R4");
    send({word(5'd1, 16'h0F0F), 8'h3C}, 32); e_hold[1] = 16'h0F0F; e_dac[1] = 16'h0F0F;
    check_all("R4");
    send(word(5'd1, 16'h9999), 24);
    check_all("R5");
    chk_mode = 1'b0;
    send({word(5'd1, 16'h8888), 8'h00}, 32);
    check_all("R5");
  endtask

  task automatic t_group;
    set_upd(1'b1);
    send(word(5'd0, 16'h1111), 24); e_hold[0] = 16'h1111;
    send(word(5'd1, 16'h2222), 24); e_hold[1] = 16'h2222;
    send(word(5'd0, 16'h3333), 24); e_hold[0] = 16'h3333;
    check_all("R8");
    check("R10", "hold[0] takes later write", 32'(hold_codes[0 +: DW]), 32'h3333);
    set_upd(1'b0);
    e_dac[0] = 16'h1111; e_dac[1] = 16'h2222;
    check_all("R9");
    check("R10", "dac[0] first write", 32'(dac_codes[0 +: DW]), 32'h1111);
    set_upd(1'b1);
    send(word(5'd0, 16'h4444), 24); e_hold[0] = 16'h4444;
    check_all("R8");
    set_upd(1'b0);
    e_dac[0] = 16'h4444;
    check_all("R9");
  endtask

  initial begin
    t_reset_busy();
    t_individual();
    t_bad_addr();
    t_bad_len();
    t_check_mode();
    t_group();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule